// File: doc/BRIEF.md
# Printer Port Register Emulator

This block stands in for a standard printer port on a byte-wide host register bus. A host sees three registers, selected by a 3-bit offset: a data register, a status register and a control register. No printer is attached. When the host raises the strobe bit in a control write while the port is selected and out of init, the block sends the last written data byte out on an internal byte stream with a one-cycle valid pulse. Busy and acknowledge status then advance by themselves, one step per host status read, the way a polling driver expects.

A control write with the strobe bit low, while select and init are high, can raise a level interrupt. This happens only if interrupt enable was already set in the stored control value. Any status read clears the interrupt. A separate input loads the read-data register, which the host reads back when the direction bit is set.

Top module: `ppreg_emu`

## Requirements
- R1: After reset, the write-data and read-data registers hold 0xFF, status reads 0xD8, control reads 0x0C, irq is 0, out_valid is 0 and rdata is 0xFF.
- R2: Offset 1 reads status and offset 2 reads control. Offsets 3 to 7 read 0xFF. The value read appears on rdata in the cycle after rd_en.
- R3: An offset-0 read returns the read-data register when control bit 5 (direction) is 1, and the write-data register when it is 0.
- R4: A control write with bit 2 (init) at 0 sets status to 0xD8.
- R5: Consider a control write with init (bit 2), select (bit 3) and strobe (bit 0) all at 1. It clears status bit 7 (busy). If the stored strobe was 0 before the write, the write-data byte appears on out_byte with out_valid high for exactly one cycle, in the cycle after the write. Otherwise nothing is sent.
- R6: Consider a control write with init and select at 1 and strobe at 0. It makes the interrupt pending only if interrupt enable (bit 4) was set in the control value stored before the write.
- R7: irq equals the pending flag. A status read returns the current status and clears the pending flag, so irq is 0 in the following cycle.
- R8: After a status read, if status bit 7 (busy) is 0 and stored strobe is 0, one step is applied. If bit 6 (ack) is 1, ack is cleared. If ack is 0, both ack and busy are set.
- R9: A cycle with ext_load at 1 loads ext_data into the read-data register.
- R10: If wr_en and rd_en are both high in a cycle, only the write takes effect and rdata keeps its value.
- R11: Writes to offset 1 and to offsets 3 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable, one cycle |
| rd_en | input | 1 | Register read enable, one cycle |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ext_load | input | 1 | Load strobe for the read-data register |
| ext_data | input | 8 | Byte loaded into the read-data register |
| out_byte | output | 8 | Byte sent by the strobe |
| out_valid | output | 1 | One-cycle valid for out_byte |
| irq | output | 1 | Level interrupt request |

## Verification
Directed sequences cover three distinctions. A strobe rise is compared with a held strobe, to separate edge detection from level detection. A strobe-low write is made both before and after interrupt enable has been stored, which shows whether the old or the new control value gates the interrupt. Repeated status reads walk busy and ack through their full cycle. Random traffic uses a fixed seed and biases control writes toward init and select high. It mixes reads, writes, unmapped offsets, simultaneous read and write, and external loads, so all register paths interleave. Every cycle is compared against a bench reference model.

// File: rtl/ppreg_emu.sv
module ppreg_emu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ext_load,
  input  logic [7:0] ext_data,
  output logic [7:0] out_byte,
  output logic       out_valid,
  output logic       irq
);
  localparam logic [7:0] ST_INIT  = 8'hD8;
  localparam logic [7:0] CTL_INIT = 8'h0C;
  localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd1, A_CTRL = 3'd2;
  localparam int B_BUSY = 7, B_ACK = 6, B_DIR = 5, B_IEN = 4, B_SEL = 3, B_INIT = 2, B_STB = 0;

  logic [7:0] wreg, rreg, stat, ctrl;
  logic       pend;
  logic       rd_go;

  assign rd_go = rd_en & ~wr_en;
  assign irq   = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wreg <= 8'hFF;
      rreg <= 8'hFF;
      stat <= ST_INIT;
      ctrl <= CTL_INIT;
      pend <= 1'b0;
      rdata <= 8'hFF;
      out_byte <= 8'h00;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (ext_load) rreg <= ext_data;
      if (wr_en) begin
        case (addr)
          A_DATA: wreg <= wdata;
          A_CTRL: begin
            if (!wdata[B_INIT]) stat <= ST_INIT;
            else if (wdata[B_SEL]) begin
              if (wdata[B_STB]) begin
                stat[B_BUSY] <= 1'b0;
                if (!ctrl[B_STB]) begin
                  out_byte  <= wreg;
                  out_valid <= 1'b1;
                end
              end else if (ctrl[B_IEN]) begin
                pend <= 1'b1;
              end
            end
            ctrl <= wdata;
          end
          default: ;
        endcase
      end else if (rd_go) begin
        case (addr)
          A_DATA: rdata <= ctrl[B_DIR] ? rreg : wreg;
          A_STAT: begin
            rdata <= stat;
            pend  <= 1'b0;
            if (!stat[B_BUSY] && !ctrl[B_STB]) begin
              if (stat[B_ACK]) stat[B_ACK] <= 1'b0;
              else begin
                stat[B_ACK]  <= 1'b1;
                stat[B_BUSY] <= 1'b1;
              end
            end
          end
          A_CTRL: rdata <= ctrl;
          default: rdata <= 8'hFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/ppreg_emu_chk.sv
module ppreg_emu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       out_valid,
  input logic       irq
);
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5
  emit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(wr_en && addr == 3'd2 && wdata[0] && wdata[2] && wdata[3]));

  // R6
  irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_en && addr == 3'd2 && !wdata[0]));

  // R7
  irq_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rd_en && !wr_en && addr == 3'd1));

  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 3'd1) |=> !irq);

  // R10
  dual_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> !$rose(irq) || $past(addr == 3'd2));
endmodule

bind ppreg_emu ppreg_emu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .out_valid(out_valid), .irq(irq)
);

// File: tb/sim_ppreg_emu.sv
module sim_ppreg_emu;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, ext_load = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, ext_data = 0;
  logic [7:0] rdata, out_byte;
  logic out_valid, irq;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] m_dw, m_dr, m_st, m_ctl, m_rdata;
  logic m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppreg_emu u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_load(ext_load), .ext_data(ext_data),
    .out_byte(out_byte), .out_valid(out_valid), .irq(irq));

  function automatic logic [7:0] f_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ctl[5] ? m_dr : m_dw;
      3'd1: return m_st;
      3'd2: return m_ctl;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] f_stat_step(input logic [7:0] s, input logic [7:0] c);
    logic [7:0] n = s;
    if (!s[7] && !c[0]) begin
      if (s[6]) n[6] = 1'b0;
      else n[7:6] = 2'b11;
    end
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dw = 8'hFF; m_dr = 8'hFF; m_st = 8'hD8; m_ctl = 8'h0C; m_pend = 0; m_rdata = 8'hFF;
  endtask

  task automatic do_op(input bit w, input bit r, input logic [2:0] a, input logic [7:0] d,
                       input bit ld, input logic [7:0] ed, input string tag);
    bit exp_emit = 0;
    logic [7:0] exp_byte = 8'h00;
    bit is_rd = r && !w;
    wr_en = w; rd_en = r; addr = a; wdata = d; ext_load = ld; ext_data = ed;
    if (is_rd) begin
      m_rdata = f_read(a);
      if (a == 3'd1) begin
        m_pend = 0;
        m_st = f_stat_step(m_st, m_ctl);
      end
    end
    if (w) begin
      if (a == 3'd0) m_dw = d;
      else if (a == 3'd2) begin
        if (!d[2]) m_st = 8'hD8;
        else if (d[3]) begin
          if (d[0]) begin
            m_st[7] = 1'b0;
            if (!m_ctl[0]) begin exp_emit = 1; exp_byte = m_dw; end
          end else if (m_ctl[4]) m_pend = 1;
        end
        m_ctl = d;
      end
    end
    if (ld) m_dr = ed;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; ext_load = 0;
    chk(out_valid == exp_emit, tag, {7'b0, out_valid}, {7'b0, exp_emit});
    if (exp_emit) chk(out_byte == exp_byte, tag, out_byte, exp_byte);
    chk(irq == m_pend, tag, {7'b0, irq}, {7'b0, m_pend});
    chk(rdata == m_rdata, tag, rdata, m_rdata);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    do_op(0, 1, a, 8'h00, 0, 8'h00, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    do_op(1, 0, a, d, 0, 8'h00, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(irq == 0, "R1", {7'b0, irq}, 8'h00);
    chk(out_valid == 0, "R1", {7'b0, out_valid}, 8'h00);
    chk(rdata == 8'hFF, "R1", rdata, 8'hFF);
    rd(3'd0, "R1"); rd(3'd1, "R1"); rd(3'd2, "R1");
    // R2 unmapped offsets
    rd(3'd5, "R2"); rd(3'd3, "R2"); rd(3'd7, "R2");
    // R11 ignored writes
    wr(3'd1, 8'h00, "R11"); rd(3'd1, "R11");
    wr(3'd6, 8'h00, "R11"); rd(3'd2, "R11"); rd(3'd0, "R11");
    // R5 strobe edge and held strobe
    wr(3'd2, 8'h0D, "R5"); wr(3'd2, 8'h0D, "R5"); rd(3'd1, "R5");
    wr(3'd0, 8'hA5, "R5"); wr(3'd2, 8'h0C, "R5"); wr(3'd2, 8'h0D, "R5");
    // R6 interrupt uses previous enable
    wr(3'd2, 8'h1C, "R6"); wr(3'd2, 8'h1C, "R6");
    // R7 and R8 status read clears irq and steps ack/busy
    rd(3'd1, "R7"); rd(3'd1, "R8"); rd(3'd1, "R8"); rd(3'd1, "R8");
    // R4 init low reloads status
    wr(3'd2, 8'h0D, "R4"); rd(3'd1, "R4"); wr(3'd2, 8'h08, "R4"); rd(3'd1, "R4");
    // R9 and R3 external load and direction
    do_op(0, 0, 3'd0, 8'h00, 1, 8'h3C, "R9");
    wr(3'd2, 8'h2C, "R3"); rd(3'd0, "R9");
    wr(3'd2, 8'h0C, "R3"); rd(3'd0, "R3");
    // R10 simultaneous read and write
    do_op(1, 1, 3'd0, 8'h5A, 0, 8'h00, "R10"); rd(3'd0, "R10");
    do_op(1, 1, 3'd2, 8'h1C, 0, 8'h00, "R10"); rd(3'd2, "R10");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit w = ($urandom % 2) == 1;
      bit r = ($urandom % 4) != 0;
      logic [2:0] a = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 3);
      logic [7:0] d = 8'($urandom);
      if (a == 3'd2 && ($urandom % 4) != 0) d = d | 8'h0C;
      if (($urandom % 8) == 0) do_op(1, 1, a, d, $urandom % 2, 8'($urandom), "R10");
      else do_op(w, !w && r, a, d, ($urandom % 6) == 0, 8'($urandom), "R2");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule